// File: doc/BRIEF.md
# Nine-Bit Command/Parameter Serial Writer

This block is a transmit-only serial master for a display controller whose link has no return line. A host hands it one request at a time. Each request holds a register address (the command byte) and a length code that selects zero, one or two parameter bytes. The block turns the request into one, two or three nine-bit words. It sends them back to back with chip select held low for the whole transaction, then reports completion with a one-cycle pulse.

Every word is shifted out most significant bit first. Its top bit tells the controller whether the low eight bits are a command or a parameter. The serial clock rests high; data moves on the falling edge and is captured by the panel on the rising edge. The block also keeps a shadow copy of the last value sent to each register address in a fixed range. The host can read any entry with one cycle of latency.

Top module: `nbw_top`

## Requirements
- R1: During and after reset, with no request pending, cs_n and sclk are 1, mosi, done and err are 0, req_ready is 1 and rd_data is 0.
- R2: Each word is 9 bits, sent MSB first; bit 8 is 0 for the command word and 1 for each parameter word, and bits 7:0 carry the byte.
- R3: Each sclk low half and high half lasts HALF_DIV clock cycles. mosi changes only while sclk is low or at its falling edge, and it holds its value across every rising edge.
- R4: cs_n falls HALF_DIV cycles before the first falling sclk edge. It stays low between the words of one transaction and rises HALF_DIV cycles after the last rising edge. mosi is 0 outside bit periods.
- R5: req_len selects the word count: 0 sends the command alone, 1 adds one word carrying req_param[7:0], and 2 adds two words, req_param[15:8] first and then req_param[7:0]. cs_n is low for exactly 2*HALF_DIV*(9*words+1) cycles.
- R6: An accepted request with req_len equal to 3 produces a one-cycle err pulse in the next cycle. It sends nothing, raises no done, and leaves the shadow unchanged.
- R7: req_ready is 0 from the cycle after acceptance until the cycle done is high. A request held valid while req_ready is 0 is not taken.
- R8: done is a single-cycle pulse, high in the first cycle that cs_n is back at 1 after a transaction.
- R9: On completion, the shadow entry at the command address takes 0 for length 0, the zero-extended byte for length 1, and the 16-bit parameter for length 2. Commands at addresses 0xEE and above are sent but not stored.
- R10: rd_data shows, one cycle after rd_addr is presented, the shadow value as it was before that clock edge. It is 0 for addresses never written since reset and for addresses 0xEE and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 8 | Command byte (register address) |
| req_len | input | 2 | Parameter length code: 0, 1, 2; 3 is rejected |
| req_param | input | 16 | Parameter value |
| done | output | 1 | Transaction finished pulse |
| err | output | 1 | Rejected request pulse |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| rd_addr | input | 8 | Shadow read address |
| rd_data | output | 16 | Shadow read value, one cycle later |

## Verification
The assertions assume that rd_addr and the request fields are known values after reset, and that req_valid drops only after a request has been accepted or while the block is busy. The bench changes every input on the falling clock edge. It asserts req_valid only when it is about to start a transfer or when it is deliberately probing the stall. It also drops any junk held during a busy period well before the transfer ends, so the reference model's view of acceptance always matches the request port.

// File: rtl/nbw_pkg.sv
`timescale 1ns/1ps
package nbw_pkg;
  localparam int WORD_W    = 9;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int BITCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LEN_NONE = 2'd0,
    LEN_BYTE = 2'd1,
    LEN_WORD = 2'd2,
    LEN_BAD  = 2'd3
  } len_e;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_SETUP,
    SH_LOW,
    SH_HIGH,
    SH_HOLD
  } sh_state_e;
endpackage

// File: rtl/nbw_framer.sv
`timescale 1ns/1ps
module nbw_framer
  import nbw_pkg::*;
(
  input  logic [7:0]          cmd_i,
  input  len_e                len_i,
  input  logic [15:0]         param_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [BITCNT_W-1:0] nbits_o,
  output logic                bad_o,
  output logic [15:0]         shadow_o
);
  localparam logic [BITCNT_W-1:0] W1 = BITCNT_W'(WORD_W);

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    localparam int HI = FRAME_W - 1 - w * WORD_W;
    if (w == 0) begin : g_cmd
      assign frame_o[HI -: WORD_W] = {1'b0, cmd_i};
    end else if (w == 1) begin : g_first
      assign frame_o[HI -: WORD_W] =
        (len_i == LEN_WORD) ? {1'b1, param_i[15:8]} :
        (len_i == LEN_BYTE) ? {1'b1, param_i[7:0]}  : '0;
    end else begin : g_second
      assign frame_o[HI -: WORD_W] =
        (len_i == LEN_WORD) ? {1'b1, param_i[7:0]} : '0;
    end
  end

  always_comb begin
    bad_o    = 1'b0;
    nbits_o  = W1;
    shadow_o = '0;
    unique case (len_i)
      LEN_NONE: begin nbits_o = W1;              shadow_o = '0;                   end
      LEN_BYTE: begin nbits_o = W1 + W1;         shadow_o = {8'h00, param_i[7:0]}; end
      LEN_WORD: begin nbits_o = W1 + W1 + W1;    shadow_o = param_i;              end
      default:  begin bad_o = 1'b1;                                               end
    endcase
  end
endmodule

// File: rtl/nbw_shifter.sv
`timescale 1ns/1ps
module nbw_shifter
  import nbw_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic [BITCNT_W-1:0] nbits_i,
  output logic                idle_o,
  output logic                last_o,
  output logic                done_o,
  output logic                sclk_o,
  output logic                cs_n_o,
  output logic                mosi_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF_DIV - 1);

  sh_state_e           st_q, st_n;
  logic [CNT_W-1:0]    hcnt_q, hcnt_n;
  logic [BITCNT_W-1:0] bit_q, bit_n, nbits_q, nbits_n;
  logic [FRAME_W-1:0]  sh_q, sh_n;
  logic                half_end;

  assign half_end = (hcnt_q == CNT_END);
  assign idle_o   = (st_q == SH_IDLE);
  assign last_o   = (st_q == SH_HOLD) && half_end;

  always_comb begin
    st_n    = st_q;
    hcnt_n  = hcnt_q;
    bit_n   = bit_q;
    nbits_n = nbits_q;
    sh_n    = sh_q;
    if (st_q != SH_IDLE) hcnt_n = half_end ? '0 : hcnt_q + 1'b1;
    unique case (st_q)
      SH_IDLE: if (start_i) begin
        st_n    = SH_SETUP;
        hcnt_n  = '0;
        bit_n   = '0;
        nbits_n = nbits_i;
        sh_n    = frame_i;
      end
      SH_SETUP: if (half_end) st_n = SH_LOW;
      SH_LOW:   if (half_end) st_n = SH_HIGH;
      SH_HIGH:  if (half_end) begin
        if (bit_q == nbits_q - 1'b1) begin
          st_n = SH_HOLD;
        end else begin
          st_n  = SH_LOW;
          bit_n = bit_q + 1'b1;
          sh_n  = {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
      SH_HOLD:  if (half_end) st_n = SH_IDLE;
      default:  st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      hcnt_q  <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      sh_q    <= '0;
      sclk_o  <= 1'b1;
      cs_n_o  <= 1'b1;
      mosi_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      st_q    <= st_n;
      hcnt_q  <= hcnt_n;
      bit_q   <= bit_n;
      nbits_q <= nbits_n;
      sh_q    <= sh_n;
      sclk_o  <= (st_n != SH_LOW);
      cs_n_o  <= (st_n == SH_IDLE);
      mosi_o  <= ((st_n == SH_LOW) || (st_n == SH_HIGH)) ? sh_n[FRAME_W-1] : 1'b0;
      done_o  <= last_o;
    end
  end

  AST_CS_HIGH_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o); // R4
  AST_MOSI_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(mosi_o)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o)); // R8
endmodule

// File: rtl/nbw_shadow.sv
`timescale 1ns/1ps
module nbw_shadow #(
  parameter int DEPTH  = 238,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic              w_in, r_in;

  assign w_in = we_i && (wa_i < LIMIT);
  assign r_in = (ra_i < LIMIT);

  always_ff @(posedge clk) begin
    if (w_in) mem_q[wa_i] <= wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_o  <= '0;
    end else begin
      if (w_in) vld_q[wa_i] <= 1'b1;
      rd_o <= (r_in && vld_q[ra_i]) ? mem_q[ra_i] : '0;
    end
  end

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ra_i) >= LIMIT) |-> (rd_o == '0)); // R10
endmodule

// File: rtl/nbw_top.sv
`timescale 1ns/1ps
module nbw_top
  import nbw_pkg::*;
#(
  parameter int HALF_DIV     = 2,
  parameter int SHADOW_DEPTH = 238
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_cmd,
  input  logic [1:0]  req_len,
  input  logic [15:0] req_param,
  output logic        done,
  output logic        err,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic [7:0]  rd_addr,
  output logic [15:0] rd_data
);
  logic [1:0]          rst_ff;
  logic                rst_s_n;
  logic                accept, start, idle, last;
  logic [FRAME_W-1:0]  frame;
  logic [BITCNT_W-1:0] nbits;
  logic                bad;
  logic [15:0]         shv;
  logic [7:0]          wa_q;
  logic [15:0]         wv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  assign req_ready = idle;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !bad;

  nbw_framer i_framer (
    .cmd_i    (req_cmd),
    .len_i    (len_e'(req_len)),
    .param_i  (req_param),
    .frame_o  (frame),
    .nbits_o  (nbits),
    .bad_o    (bad),
    .shadow_o (shv)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wa_q <= '0;
      wv_q <= '0;
      err  <= 1'b0;
    end else begin
      if (start) begin
        wa_q <= req_cmd;
        wv_q <= shv;
      end
      err <= accept && bad;
    end
  end

  nbw_shifter #(.HALF_DIV(HALF_DIV)) i_shifter (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (start),
    .frame_i (frame),
    .nbits_i (nbits),
    .idle_o  (idle),
    .last_o  (last),
    .done_o  (done),
    .sclk_o  (sclk),
    .cs_n_o  (cs_n),
    .mosi_o  (mosi)
  );

  nbw_shadow #(.DEPTH(SHADOW_DEPTH), .ADDR_W(8), .DATA_W(16)) i_shadow (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we_i  (last),
    .wa_i  (wa_q),
    .wd_i  (wv_q),
    .ra_i  (rd_addr),
    .rd_o  (rd_data)
  );

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    err |-> (cs_n && !done)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_n |-> !req_ready); // R7
endmodule

// File: tb/test_nbw_top.sv
`timescale 1ns/1ps
module test_nbw_top;
  localparam int N     = 3;
  localparam int DEPTH = 238;

  typedef struct packed {
    logic       cs_n, sclk, mosi, rdy, dn, er, we;
    logic [7:0] wa;
    logic [15:0] wv;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n, req_valid, req_ready, done, err, sclk, mosi, cs_n;
  logic [7:0] req_cmd, rd_addr;
  logic [1:0] req_len;
  logic [15:0] req_param, rd_data;

  int checks = 0, failures = 0;
  ent_t q[$];
  int exp_len[$];
  int sh[256];
  bit shv[256];
  logic cur_ready = 1'b1;
  logic prev_cs = 1'b1;
  int cs_run = 0;

  always #2.5 clk = ~clk;

  nbw_top #(.HALF_DIV(N), .SHADOW_DEPTH(DEPTH)) i_nbw_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_len(req_len), .req_param(req_param),
    .done(done), .err(err), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic ent_t mk(logic c, logic s, logic m);
    ent_t e = '0;
    e.cs_n = c; e.sclk = s; e.mosi = m;
    return e;
  endfunction

  // Reference: builds the per-cycle pin picture of a request (R2, R4, R5, R6)
  task automatic push_req(logic [7:0] c, logic [1:0] l, logic [15:0] p);
    ent_t e;
    logic [8:0] words[3];
    int nw;
    if (l == 2'd3) begin
      e = mk(1, 1, 0); e.rdy = 1; e.er = 1;
      q.push_back(e);
      return;
    end
    nw = l + 1;
    words[0] = {1'b0, c};
    words[1] = (l == 2) ? {1'b1, p[15:8]} : {1'b1, p[7:0]};
    words[2] = {1'b1, p[7:0]};
    for (int i = 0; i < N; i++) q.push_back(mk(0, 1, 0));
    for (int w = 0; w < nw; w++)
      for (int b = 8; b >= 0; b--) begin
        for (int i = 0; i < N; i++) q.push_back(mk(0, 0, words[w][b]));
        for (int i = 0; i < N; i++) q.push_back(mk(0, 1, words[w][b]));
      end
    for (int i = 0; i < N; i++) q.push_back(mk(0, 1, 0));
    e = mk(1, 1, 0); e.rdy = 1; e.dn = 1; e.we = 1; e.wa = c;
    e.wv = (l == 0) ? 16'h0 : (l == 1) ? {8'h0, p[7:0]} : p;
    q.push_back(e);
    exp_len.push_back(2 * N * (9 * nw + 1));
  endtask

  task automatic step();
    logic [7:0] a_prev;
    ent_t e;
    int exp_rd;
    a_prev = rd_addr;
    if (req_valid && cur_ready) push_req(req_cmd, req_len, req_param);
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin e = mk(1, 1, 0); e.rdy = 1; end
    chk("R4 cs_n", cs_n, e.cs_n);
    chk("R3 sclk", sclk, e.sclk);
    chk("R2 mosi", mosi, e.mosi);
    chk("R7 req_ready", req_ready, e.rdy);
    chk("R8 done", done, e.dn);
    chk("R6 err", err, e.er);
    exp_rd = (a_prev < DEPTH && shv[a_prev]) ? sh[a_prev] : 0;
    if (a_prev < DEPTH) chk("R9 rd_data", rd_data, exp_rd);
    else                chk("R10 rd_data", rd_data, exp_rd);
    if (e.we && e.wa < DEPTH) begin sh[e.wa] = e.wv; shv[e.wa] = 1'b1; end
    cur_ready = e.rdy;
    if (cs_n == 1'b0) cs_run++;
    else if (prev_cs == 1'b0) begin
      chk("R5 cs_low_cycles", cs_run, (exp_len.size() > 0) ? exp_len.pop_front() : -1);
      cs_run = 0;
    end
    prev_cs = cs_n;
  endtask

  task automatic send(logic [7:0] c, logic [1:0] l, logic [15:0] p);
    while (!cur_ready) step();
    req_cmd = c; req_len = l; req_param = p; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin sh[i] = 0; shv[i] = 1'b0; end
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_len = '0;
    req_param = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset pin state
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 1); chk("R1 mosi", mosi, 0);
    chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 req_ready", req_ready, 1); chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R5 length 2: high byte then low byte; R9 stores 16 bits
    rd_addr = 8'hC3;
    send(8'hC3, 2'd2, 16'h2040);
    drain();
    // R5 length 1 with junk in the high byte; R9 zero-extends
    rd_addr = 8'h3A;
    send(8'h3A, 2'd1, 16'hAB60);
    drain();
    // R7: hold a different request valid while busy; it must not be taken
    rd_addr = 8'h29;
    send(8'h29, 2'd2, 16'h1234);
    req_cmd = 8'h55; req_len = 2'd1; req_param = 16'h00EE; req_valid = 1'b1;
    repeat (6) step();
    req_valid = 1'b0;
    drain();
    // R5 length 0 overwrites with 0 (R9)
    send(8'h29, 2'd0, 16'hFFFF);
    drain();
    rd_addr = 8'h55;
    repeat (2) step();
    // R6: bad length leaves shadow and pins alone
    rd_addr = 8'hC3;
    send(8'hC3, 2'd3, 16'h9999);
    repeat (3) step();
    // back-to-back starts on the done cycle (R8, R7)
    send(8'hB0, 2'd1, 16'h0011);
    send(8'hB8, 2'd2, 16'hFFF9);
    drain();
    rd_addr = 8'hB8;
    repeat (2) step();
    // R9/R10: command above the shadow range is sent but not stored
    rd_addr = 8'hEE;
    send(8'hEE, 2'd1, 16'h0077);
    drain();
    rd_addr = 8'hFF; repeat (2) step();
    rd_addr = 8'h10; repeat (2) step();   // R10 never written
    rd_addr = 8'hED;
    send(8'hED, 2'd2, 16'hA55A);         // last in-range address
    drain();
    repeat (2) step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule